// File: doc/BRIEF.md
# Fragment Depth Comparison Stage

This block is one stage of a fragment pipeline. It decides per fragment whether the fragment survives the depth test and whether the depth buffer should take the fragment's depth. Software configures it through a small register-write port. One register holds the test enable, the compare function and the depth-write enable. A second register holds the placement bit, which selects whether the test runs before texturing (early) or after it (late).

Each fragment arrives with a valid flag, its own 24-bit depth, the depth already stored at its position, and a stage tag that says which of the two placements it is passing through. The block applies the test only at the placement the configuration selects. Fragments at the other placement, and all fragments while the test is disabled, pass unchanged. The verdict and the write strobe come out registered, one cycle after the fragment.

Top module: `depth_test_unit`

## Requirements
- R1: After reset, out_valid, out_pass and out_zwrite are 0. The configuration resets to all zero: test disabled, compare code 0, depth write disabled, placement late.
- R2: The compare code selects how the incoming depth relates to the stored depth: 0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal, 7 always. Both depths are 24-bit unsigned, and the incoming depth is the left operand.
- R3: A write to address MODE_ADDR (default 0x10) loads the test enable from data bit 0, the compare code from bits 3:1 and the depth-write enable from bit 4.
- R4: A write to address CTRL_ADDR (default 0x11) loads the early-placement bit from data bit 6.
- R5: A fragment whose stage tag is 0 (before texturing) is tested only when both the early bit and the test enable are 1.
- R6: A fragment whose stage tag is 1 (after texturing) is tested only when the early bit is 0 and the test enable is 1.
- R7: A valid fragment at a stage where the test is not active always passes.
- R8: out_zwrite is 1 only when the fragment passes and the depth-write enable is 1.
- R9: The outputs appear one clock after the fragment is presented, and out_valid follows frag_valid. When out_valid is 0, out_pass and out_zwrite are 0.
- R10: A configuration write affects only fragments presented after the write cycle. A fragment presented in the same cycle as a write uses the old value. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| frag_valid | input | 1 | Fragment present this cycle |
| frag_z_in | input | 24 | Incoming fragment depth |
| frag_z_stored | input | 24 | Depth currently stored at the fragment position |
| frag_after_tex | input | 1 | Stage tag: 0 before texturing, 1 after |
| out_valid | output | 1 | Registered fragment valid |
| out_pass | output | 1 | Fragment survives the depth stage |
| out_zwrite | output | 1 | Write the incoming depth to the depth buffer |

## Verification
If a configuration field is held wrongly, nothing shows until the next valid fragment reaches a stage where the test is active. Its verdict is then wrong one cycle later. If the depth-write enable is held wrongly, the error shows on out_zwrite for the first passing fragment. For these reasons the bench sweeps every compare code against less, equal and greater depth pairs at both placements. It also places writes in the same cycle as fragments, so that a stale or early configuration update shows on the very next output. A fault in the placement decode shows as a kill at a stage that should be transparent, which the bench reaches by sending fragments tagged for both stages under both placement settings.

// File: rtl/depth_test_pkg.sv
// Shared types and field positions for the fragment depth stage.
// Assumes the compare code bits mean: bit0 less, bit1 equal, bit2 greater.
package depth_test_pkg;

    typedef enum logic [2:0] {
        CMP_NEVER  = 3'd0,
        CMP_LT     = 3'd1,
        CMP_EQ     = 3'd2,
        CMP_LE     = 3'd3,
        CMP_GT     = 3'd4,
        CMP_NE     = 3'd5,
        CMP_GE     = 3'd6,
        CMP_ALWAYS = 3'd7
    } cmp_fn_e;

    typedef struct packed {
        logic    test_en;
        cmp_fn_e fn;
        logic    upd_en;
        logic    early;
    } dt_cfg_t;

    localparam int MODE_EN_BIT   = 0;
    localparam int MODE_FN_LSB   = 1;
    localparam int MODE_FN_W     = 3;
    localparam int MODE_UPD_BIT  = 4;
    localparam int CTRL_EARLY_BIT = 6;

endpackage

// File: rtl/dt_cfg_regs.sv
// Configuration registers for the depth stage.
// Decodes writes to the mode and control addresses and ignores all others.
// Assumes DATA_W is wide enough to hold the highest field bit.
module dt_cfg_regs
    import depth_test_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 32,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 'h10,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output dt_cfg_t           cfg
);

    localparam logic [DATA_W-1:0] USED_MASK =
        (DATA_W'(1) << MODE_EN_BIT) |
        (DATA_W'(7) << MODE_FN_LSB) |
        (DATA_W'(1) << MODE_UPD_BIT) |
        (DATA_W'(1) << CTRL_EARLY_BIT);

    logic mode_hit;
    logic ctrl_hit;
    logic unused_wdata_bits;

    // Address decode for the two registers.
    assign mode_hit = wr_en && (wr_addr == MODE_ADDR);
    assign ctrl_hit = wr_en && (wr_addr == CTRL_ADDR);
    assign unused_wdata_bits = ^(wr_data & ~USED_MASK);

    // Mode register: enable, compare code, depth-write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.test_en <= 1'b0;
            cfg.fn      <= CMP_NEVER;
            cfg.upd_en  <= 1'b0;
        end else if (mode_hit) begin
            cfg.test_en <= wr_data[MODE_EN_BIT];
            cfg.fn      <= cmp_fn_e'(wr_data[MODE_FN_LSB +: MODE_FN_W]);
            cfg.upd_en  <= wr_data[MODE_UPD_BIT];
        end
    end

    // Control register: early placement bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.early <= 1'b0;
        end else if (ctrl_hit) begin
            cfg.early <= wr_data[CTRL_EARLY_BIT];
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg));

    p_mode_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == MODE_ADDR) |=>
            (cfg.test_en == $past(wr_data[MODE_EN_BIT])) &&
            (cfg.upd_en == $past(wr_data[MODE_UPD_BIT])));

    p_ctrl_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CTRL_ADDR) |=>
            (cfg.early == $past(wr_data[CTRL_EARLY_BIT])));

endmodule

// File: rtl/dt_depth_cmp.sv
// Unsigned depth comparator. Combinational; the code's three bits enable the
// less, equal and greater outcomes, so any of the eight functions is an OR.
module dt_depth_cmp
    import depth_test_pkg::*;
#(
    parameter int Z_W = 24
) (
    input  cmp_fn_e        fn,
    input  logic [Z_W-1:0] z_new,
    input  logic [Z_W-1:0] z_old,
    output logic           hit
);

    logic lt;
    logic eq;
    logic gt;

    // Magnitude relation of incoming depth against stored depth.
    always_comb begin
        lt = z_new < z_old;
        eq = z_new == z_old;
        gt = !lt && !eq;
    end

    // Select allowed outcomes from the code bits.
    assign hit = (fn[0] & lt) | (fn[1] & eq) | (fn[2] & gt);

endmodule

// File: rtl/dt_stage_gate.sv
// Placement gate and output register. Decides whether the test applies at the
// fragment's stage, forms pass and write strobe, and registers them with valid.
module dt_stage_gate
    import depth_test_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  dt_cfg_t cfg,
    input  logic    in_valid,
    input  logic    in_late,
    input  logic    cmp_hit,
    output logic    out_valid,
    output logic    out_pass,
    output logic    out_zwrite
);

    logic active;
    logic pass_d;

    // Test runs only at the stage chosen by the placement bit.
    assign active = cfg.test_en && (in_late ? !cfg.early : cfg.early);
    assign pass_d = in_valid && (!active || cmp_hit);

    // One-cycle output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_pass   <= 1'b0;
            out_zwrite <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            out_pass   <= pass_d;
            out_zwrite <= pass_d && cfg.upd_en;
        end
    end

    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_pass && !out_zwrite));

    p_zwrite_needs_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_zwrite |-> out_pass);

    p_inactive_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !active) |=> out_pass);

    p_early_stage_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_late && !cfg.early) |=> out_pass);

    p_late_stage_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_late && cfg.early) |=> out_pass);

    p_never_kills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && active && cfg.fn == CMP_NEVER) |=> !out_pass);

    p_always_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg.fn == CMP_ALWAYS) |=> out_pass);

endmodule

// File: rtl/depth_test_unit.sv
// Top of the fragment depth stage: configuration registers, comparator and
// placement gate. Assumes depth format conversion happens upstream.
module depth_test_unit
    import depth_test_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter int                Z_W       = 24,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 'h10,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              frag_valid,
    input  logic [Z_W-1:0]    frag_z_in,
    input  logic [Z_W-1:0]    frag_z_stored,
    input  logic              frag_after_tex,
    output logic              out_valid,
    output logic              out_pass,
    output logic              out_zwrite
);

    dt_cfg_t cfg;
    logic    cmp_hit;

    dt_cfg_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .MODE_ADDR (MODE_ADDR),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .cfg     (cfg)
    );

    dt_depth_cmp #(
        .Z_W (Z_W)
    ) u_cmp (
        .fn    (cfg.fn),
        .z_new (frag_z_in),
        .z_old (frag_z_stored),
        .hit   (cmp_hit)
    );

    dt_stage_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .in_valid   (frag_valid),
        .in_late    (frag_after_tex),
        .cmp_hit    (cmp_hit),
        .out_valid  (out_valid),
        .out_pass   (out_pass),
        .out_zwrite (out_zwrite)
    );

endmodule

// File: tb/depth_test_unit_test.sv
module depth_test_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int MODE_A = 'h10;
    localparam int CTRL_A = 'h11;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [7:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        frag_valid;
    logic [23:0] frag_z_in;
    logic [23:0] frag_z_stored;
    logic        frag_after_tex;
    logic        out_valid;
    logic        out_pass;
    logic        out_zwrite;

    int n_checks = 0;
    int n_fail = 0;

    // Behavioural model of the configuration.
    int m_en = 0, m_fn = 0, m_upd = 0, m_early = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    depth_test_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frag_valid(frag_valid), .frag_z_in(frag_z_in),
        .frag_z_stored(frag_z_stored), .frag_after_tex(frag_after_tex),
        .out_valid(out_valid), .out_pass(out_pass), .out_zwrite(out_zwrite)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit ref_cmp(int fn, int a, int b);
        case (fn)
            0: return 0;
            1: return a < b;
            2: return a == b;
            3: return a <= b;
            4: return a > b;
            5: return a != b;
            6: return a >= b;
            default: return 1;
        endcase
    endfunction

    // Present one cycle of stimulus, then check the registered result.
    task automatic tick(string tag, bit we, int addr, int data,
                        bit v, int zi, int zs, bit late);
        bit act_t, ep, ez;
        cfg_wr_en      = we;
        cfg_addr       = addr[7:0];
        cfg_wdata      = data;
        frag_valid     = v;
        frag_z_in      = zi[23:0];
        frag_z_stored  = zs[23:0];
        frag_after_tex = late;
        @(negedge clk);
        act_t = (m_en != 0) && (late ? (m_early == 0) : (m_early != 0));
        ep = v && (!act_t || ref_cmp(m_fn, zi & 'hFFFFFF, zs & 'hFFFFFF));
        ez = ep && (m_upd != 0);
        chk("R9 valid", out_valid, v);
        chk({tag, " pass"}, out_pass, ep);
        chk("R8 zwrite", out_zwrite, ez);
        if (we && addr == MODE_A) begin
            m_en = data & 1; m_fn = (data >> 1) & 7; m_upd = (data >> 4) & 1;
        end else if (we && addr == CTRL_A) begin
            m_early = (data >> 6) & 1;
        end
    endtask

    task automatic set_mode(bit en, int fn, bit upd);
        tick("R3", 1, MODE_A, (upd << 4) | (fn << 1) | en, 0, 0, 0, 0);
    endtask

    task automatic set_early(bit e);
        tick("R4", 1, CTRL_A, e << 6, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; cfg_wr_en = 0; cfg_addr = 0; cfg_wdata = 0; frag_valid = 0;
        frag_z_in = 0; frag_z_stored = 0; frag_after_tex = 0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared by reset
        chk("R1 valid", out_valid, 0);
        chk("R1 pass", out_pass, 0);
        chk("R1 zwrite", out_zwrite, 0);
        rst_n = 1;
        // R1: reset config disables the test, so all fragments pass, no write
        tick("R1", 0, 0, 0, 1, 5, 9, 0);
        tick("R1", 0, 0, 0, 1, 9, 5, 1);
        tick("R9", 0, 0, 0, 0, 9, 5, 1);

        // R2/R6: each compare code at the late stage, early stage transparent
        for (int e = 0; e < 2; e++) begin
            set_early(e[0]);
            for (int fn = 0; fn < 8; fn++) begin
                set_mode(1, fn, fn[0]);
                for (int st = 0; st < 2; st++) begin
                    string tg;
                    tg = (st == 1) ? ((e == 0) ? "R2" : "R6") : ((e == 1) ? "R2" : "R5");
                    tick(tg, 0, 0, 0, 1, 100, 200, st[0]);
                    tick(tg, 0, 0, 0, 1, 200, 200, st[0]);
                    tick(tg, 0, 0, 0, 1, 300, 200, st[0]);
                    tick(tg, 0, 0, 0, 1, 'hFFFFFF, 0, st[0]);
                    tick(tg, 0, 0, 0, 1, 0, 'hFFFFFF, st[0]);
                end
            end
        end

        // R7: test disabled with a killing code passes at both stages
        set_mode(0, 0, 1);
        tick("R7", 0, 0, 0, 1, 1, 2, 0);
        tick("R7", 0, 0, 0, 1, 1, 2, 1);

        // R10: write in the same cycle as a fragment uses the old config
        set_early(0);
        set_mode(1, 7, 1);
        tick("R10", 1, MODE_A, 1, 1, 7, 7, 1);
        tick("R10", 0, 0, 0, 1, 7, 7, 1);
        tick("R10", 1, CTRL_A, 'h40, 1, 3, 3, 1);
        tick("R10", 0, 0, 0, 1, 3, 3, 1);
        // R10: writes to other addresses are ignored
        set_early(0);
        set_mode(1, 0, 1);
        for (int a = 0; a < 256; a += 7) begin
            if (a != MODE_A && a != CTRL_A)
                tick("R10", 1, a, 'hFFFFFFFF, 1, a, a, a[0]);
        end
        tick("R10", 0, 0, 0, 1, 4, 4, 1);

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int r, addr, zs, zi;
            r = $urandom_range(0, 9);
            addr = (r == 0) ? MODE_A : (r == 1) ? CTRL_A : (r == 2) ? $urandom_range(0, 255) : 0;
            zs = $urandom & 'hFFFFFF;
            case ($urandom_range(0, 3))
                0: zi = zs;
                1: zi = (zs + 1) & 'hFFFFFF;
                2: zi = (zs - 1) & 'hFFFFFF;
                default: zi = $urandom & 'hFFFFFF;
            endcase
            tick("R2", r <= 2, addr, $urandom, $urandom_range(0, 3) != 0, zi, zs,
                 $urandom_range(0, 1) == 1);
        end
        tick("R9", 0, 0, 0, 0, 0, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule